// File: doc/BRIEF.md
# Interrupt flag and enable controller

This block collects the interrupt events of a small microcontroller and decides when the core must take an interrupt. It watches four event sources:
- a timer overflow pulse;
- an external interrupt pin with a programmable edge;
- a pin-change detector on a fixed subset of port pins;
- a conversion-done pulse from an analog converter.

Each source sets a sticky flag. Software reads and clears the flags through a small register bus.

Three registers are visible on the bus:
- **Status/enable register** (address 0): the three core flags, their enables, a peripheral-group enable and the global enable.
- **Peripheral flag register** (address 1): holds the conversion-done flag.
- **Peripheral enable register** (address 2): holds the matching enable.

A sequencer with three states handles entry to and return from the handler:
- **RUN**: the core runs normal code.
- **REQ**: a request is raised to the core.
- **ISR**: the handler is running.

The sequencer moves along these transitions:
- RUN goes to REQ when the global enable is set and an enabled flag is pending.
- REQ goes to ISR on the core's acknowledge. This also clears the global enable.
- REQ goes back to RUN if the request condition disappears before it is acknowledged.
- ISR goes to RUN on return-from-interrupt. This sets the global enable again.

The request carries the vector address where the core resumes.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, addresses 0, 1 and 2 read 0x00 and `irq_req` is 0.
- R2: Status bit 0 (pin-change flag) sets when synchronised port pin 0, 1 or 3 changes level; a change on pins 2, 4 or 5 leaves it unchanged.
- R3: Status bit 1 (external flag) sets on a falling edge of `ext_pin` when `ext_rise_sel` is 0 and on a rising edge when it is 1; the other edge leaves it unchanged.
- R4: A `timer_ovf` pulse sets status bit 2 whatever the enables are; every flag stays set until a bus write to its register clears it.
- R5: A `conv_done` pulse sets bit 6 of the peripheral flag register (address 1).
- R6: `irq_req` is never 1 while status bit 7 (global enable) is 0.
- R7: With the global enable set, a request needs one of the following: status bit 0 with bit 3, bit 1 with bit 4, or bit 2 with bit 5. Otherwise it needs peripheral flag bit 6 with peripheral enable bit 6 and status bit 6 (group enable). The group enable has no effect on the first three sources.
- R8: `irq_ack` while `irq_req` is 1 clears status bit 7 at that clock edge and drops `irq_req`; the flags are kept.
- R9: `irq_ret` sets status bit 7 at that clock edge; a still-pending enabled flag raises `irq_req` again one cycle later.
- R10: `vec_addr` equals 4.
- R11: Only bit 6 of addresses 1 and 2 is implemented; the other bits and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| timer_ovf | input | 1 | Timer overflow pulse |
| conv_done | input | 1 | Conversion complete pulse |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| ext_rise_sel | input | 1 | Edge select: 0 falling, 1 rising |
| port_pins | input | 6 | Port pins (asynchronous) |
| irq_ack | input | 1 | Core accepts the request |
| irq_ret | input | 1 | Core executes return-from-interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| vec_addr | output | 10 | Interrupt vector address |

## Verification
The bench uses the default build:
- six port pins, with the change mask on pins 0, 1 and 3;
- a two-stage synchroniser;
- a 10-bit vector of value 4.

With these values the bench toggles every port pin on its own, which covers each pin of the change mask and each pin outside it. It also drives both edges under both edge selections.

For every source it walks all eight combinations of source enable, group enable and global enable. This shows the two-level gating, and shows that the group enable has no effect on the three core sources. Finally it steps the sequencer through RUN, REQ, ISR and back to REQ with a flag left pending.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_REQ = 2'd1,
        ST_ISR = 2'd2
    } irq_state_e;

    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_PFLG = 2'd1;
    localparam logic [1:0] A_PEN  = 2'd2;

    localparam int B_CHG_F = 0;
    localparam int B_EXT_F = 1;
    localparam int B_TMR_F = 2;
    localparam int B_CHG_E = 3;
    localparam int B_EXT_E = 4;
    localparam int B_TMR_E = 5;
    localparam int B_GRP_E = 6;
    localparam int B_GIE   = 7;
    localparam int B_CONV  = 6;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar k = 0; k < STAGES; k++) begin : g_stg
        logic [W-1:0] q_r;
        if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= g_stg[k-1].q_r;
            end
        end
    end

    assign q = g_stg[STAGES-1].q_r;
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
    parameter int              PORT_W   = 6,
    parameter logic [PORT_W-1:0] CHG_MASK = 6'b001011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_s,
    input  logic              ext_s,
    input  logic              ext_rise_sel,
    output logic              chg_evt,
    output logic              ext_evt
);
    logic [PORT_W-1:0] port_prev;
    logic              ext_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_prev <= '0;
            ext_prev  <= 1'b0;
        end else begin
            port_prev <= port_s;
            ext_prev  <= ext_s;
        end
    end

    always_comb begin
        chg_evt = |((port_s ^ port_prev) & CHG_MASK);
        ext_evt = ext_rise_sel ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gie,
    input  logic pending,
    input  logic irq_ack,
    input  logic irq_ret,
    output logic irq_req,
    output logic gie_clr,
    output logic gie_set
);
    irq_state_e state_q, state_d;
    logic       want;

    assign want = gie && pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (want) state_d = ST_REQ;
            ST_REQ: begin
                if (want && irq_ack) state_d = ST_ISR;
                else if (!want)      state_d = ST_RUN;
            end
            ST_ISR: if (irq_ret) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        irq_req = (state_q == ST_REQ) && want;
        gie_clr = irq_req && irq_ack;
        gie_set = irq_ret;
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int                PORT_W      = 6,
    parameter logic [PORT_W-1:0] CHG_MASK    = 6'b001011,
    parameter int                SYNC_STAGES = 2,
    parameter int                PC_W        = 10,
    parameter int                VECTOR      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              timer_ovf,
    input  logic              conv_done,
    input  logic              ext_pin,
    input  logic              ext_rise_sel,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic [PC_W-1:0]   vec_addr
);
    localparam int SW = PORT_W + 1;

    logic [SW-1:0] pins_s;
    logic          chg_evt, ext_evt;
    logic          gie_clr, gie_set, pending;
    logic [7:0]    stat_q;
    logic          pflg_q, pen_q;

    irq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ext_pin, port_pins}), .q(pins_s)
    );

    irq_event_detect #(.PORT_W(PORT_W), .CHG_MASK(CHG_MASK)) u_det (
        .clk(clk), .rst_n(rst_n),
        .port_s(pins_s[PORT_W-1:0]), .ext_s(pins_s[PORT_W]),
        .ext_rise_sel(ext_rise_sel),
        .chg_evt(chg_evt), .ext_evt(ext_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            pflg_q <= 1'b0;
            pen_q  <= 1'b0;
        end else begin
            if (wr_en && addr == A_STAT) stat_q <= wdata;
            if (wr_en && addr == A_PFLG) pflg_q <= wdata[B_CONV];
            if (wr_en && addr == A_PEN)  pen_q  <= wdata[B_CONV];
            if (chg_evt)   stat_q[B_CHG_F] <= 1'b1;
            if (ext_evt)   stat_q[B_EXT_F] <= 1'b1;
            if (timer_ovf) stat_q[B_TMR_F] <= 1'b1;
            if (conv_done) pflg_q <= 1'b1;
            if (gie_set)   stat_q[B_GIE] <= 1'b1;
            if (gie_clr)   stat_q[B_GIE] <= 1'b0;
        end
    end

    always_comb begin
        pending = (stat_q[B_CHG_F] && stat_q[B_CHG_E])
               || (stat_q[B_EXT_F] && stat_q[B_EXT_E])
               || (stat_q[B_TMR_F] && stat_q[B_TMR_E])
               || (pflg_q && pen_q && stat_q[B_GRP_E]);
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_STAT:  rdata = stat_q;
            A_PFLG:  rdata[B_CONV] = pflg_q;
            A_PEN:   rdata[B_CONV] = pen_q;
            default: rdata = '0;
        endcase
    end

    irq_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .gie(stat_q[B_GIE]), .pending(pending),
        .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .gie_clr(gie_clr), .gie_set(gie_set)
    );

    assign vec_addr = PC_W'(VECTOR);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic       timer_ovf,
    input logic       conv_done,
    input logic       irq_ack,
    input logic       irq_ret,
    input logic       irq_req,
    input logic [7:0] stat,
    input logic       pflg
);
    a_r6_no_req_without_gie: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[7] |-> !irq_req);

    a_r8_ack_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !stat[7]);

    a_r9_ret_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !(irq_req && irq_ack)) |=> stat[7]);

    a_r4_timer_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        timer_ovf |=> stat[2]);

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[2] && !(wr_en && addr == 2'd0)) |=> stat[2]);

    a_r5_conv_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> pflg);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .timer_ovf(timer_ovf), .conv_done(conv_done),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
    .stat(stat_q), .pflg(pflg_q)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       timer_ovf = 1'b0, conv_done = 1'b0;
    logic       ext_pin = 1'b0, ext_rise_sel = 1'b0;
    logic [5:0] port_pins = 6'd0;
    logic       irq_ack = 1'b0, irq_ret = 1'b0;
    logic       irq_req;
    logic [9:0] vec_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;
    localparam logic [5:0] MASK = 6'b001011;

    always #10 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .timer_ovf(timer_ovf), .conv_done(conv_done),
        .ext_pin(ext_pin), .ext_rise_sel(ext_rise_sel), .port_pins(port_pins),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .vec_addr(vec_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic clear_all();
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd2, 8'h00);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: timer_ovf = 1'b1;
            1: conv_done = 1'b1;
            2: irq_ack = 1'b1;
            default: irq_ret = 1'b1;
        endcase
        @(negedge clk);
        timer_ovf = 1'b0; conv_done = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 3; a++) begin
            bus_rd(2'(a), rd);
            chk("R1 reset reg", rd, 0);
        end
        chk("R1 reset irq_req", irq_req, 0);

        // R2 pin-change sweep over every port pin
        for (int i = 0; i < 6; i++) begin
            bus_wr(2'd0, 8'h00);
            port_pins[i] = ~port_pins[i];
            idle(5);
            bus_rd(2'd0, rd);
            chk($sformatf("R2 pin %0d up", i), rd[0], int'(MASK[i]));
            bus_wr(2'd0, 8'h00);
            port_pins[i] = ~port_pins[i];
            idle(5);
            bus_rd(2'd0, rd);
            chk($sformatf("R2 pin %0d down", i), rd[0], int'(MASK[i]));
        end
        bus_wr(2'd0, 8'h00);

        // R3 edge selection, both edges under both selections
        for (int s = 0; s < 2; s++) begin
            ext_rise_sel = s[0];
            idle(2);
            bus_wr(2'd0, 8'h00);
            ext_pin = 1'b1;
            idle(5);
            bus_rd(2'd0, rd);
            chk($sformatf("R3 sel %0d rise", s), rd[1], s);
            bus_wr(2'd0, 8'h00);
            ext_pin = 1'b0;
            idle(5);
            bus_rd(2'd0, rd);
            chk($sformatf("R3 sel %0d fall", s), rd[1], 1 - s);
        end
        bus_wr(2'd0, 8'h00);

        // R4 timer flag sets with enables off and stays
        pulse(0);
        idle(10);
        bus_rd(2'd0, rd);
        chk("R4 timer flag sticky", rd, 8'h04);
        chk("R6 no req with gie 0", irq_req, 0);
        bus_wr(2'd0, 8'h00);
        bus_rd(2'd0, rd);
        chk("R4 cleared by write", rd, 0);

        // R5 conversion flag, R11 unimplemented bits
        pulse(1);
        idle(2);
        bus_rd(2'd1, rd);
        chk("R5 conv flag", rd, 8'h40);
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, rd);
        chk("R11 pflag bits", rd, 8'h40);
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd2, rd);
        chk("R11 pen bits", rd, 8'h40);
        bus_rd(2'd3, rd);
        chk("R11 addr 3", rd, 0);
        clear_all();

        // R6 R7 R10 masking sweep: every source, every enable combination
        for (int src = 0; src < 4; src++) begin
            for (int c = 0; c < 8; c++) begin
                int en, grp, g, exp;
                logic [7:0] st;
                en = c & 1; grp = (c >> 1) & 1; g = (c >> 2) & 1;
                clear_all();
                if (src == 3) begin
                    bus_wr(2'd2, en ? 8'h40 : 8'h00);
                    bus_wr(2'd1, 8'h40);
                    st = 8'((grp << 6) | (g << 7));
                    exp = g & en & grp;
                end else begin
                    st = 8'((1 << src) | (en << (src + 3)) | (grp << 6) | (g << 7));
                    exp = g & en;
                end
                bus_wr(2'd0, st);
                idle(2);
                chk($sformatf("R7 src %0d combo %0d", src, c), irq_req, exp);
                if (exp == 1) chk("R10 vector", vec_addr, 4);
            end
        end
        clear_all();
        idle(2);

        // R8 R9 sequencing
        bus_wr(2'd0, 8'hA4);
        idle(2);
        chk("R9 req before ack", irq_req, 1);
        pulse(2);
        chk("R8 req dropped", irq_req, 0);
        bus_rd(2'd0, rd);
        chk("R8 gie cleared flags kept", rd, 8'h24);
        idle(3);
        chk("R8 no req in handler", irq_req, 0);
        pulse(3);
        bus_rd(2'd0, rd);
        chk("R9 gie set", rd, 8'hA4);
        idle(2);
        chk("R9 req again", irq_req, 1);
        bus_wr(2'd0, 8'hA0);
        idle(2);
        chk("R4 req gone after clear", irq_req, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule